// File: doc/BRIEF.md
# Oversampled SPI Slave Register Port

This block lets an external host reach a controller's registers over a four-wire serial link. It uses only the system clock. The serial clock, the chip select and the input data are treated as ordinary data signals. Each one passes through a synchroniser, and the block finds the serial clock edges by comparing successive samples. The host must therefore hold each serial clock phase for at least three system clocks. It must also keep chip select low for at least three system clocks before the first serial clock edge and after the last one.

Each frame carries a fixed 32-bit word in each direction. As soon as the falling chip select is seen, the output line shows the controller's interrupt flag. That flag takes the top bit slot of the outgoing word. The 31 response bits follow it, one after each falling serial clock edge. The incoming word is sampled on rising serial clock edges, most significant bit first.

When chip select rises after exactly 32 rising edges, the block does two things. It presents the received word with a single-cycle write strobe. In the same cycle it captures the parallel read data, which becomes the response for the next frame. A frame with any other bit count is dropped.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, `sdo_o` is 0, `wr_valid_o` is 0 and `wr_data_o` is all zeros. The stored response word is zero.
- R2: `sdi_i` is sampled on each rising `sck_i` edge while `cs_n_i` is low, most significant bit first. The first sampled bit becomes bit 31 of the word.
- R3: When `cs_n_i` rises after exactly 32 rising `sck_i` edges, `wr_valid_o` pulses high for one clock and `wr_data_o` takes the received word. `wr_data_o` holds that value until the next such pulse.
- R4: Within 3 clocks of `cs_n_i` falling, `sdo_o` shows the value of `irq_i`. This is the first bit the host samples.
- R5: After the k-th falling `sck_i` edge of a frame (k = 1..31), `sdo_o` shows bit 31-k of the response word within 3 clocks. After the 32nd falling edge it shows 0.
- R6: The response word is 31 bits wide. It is loaded from `rd_data_i` in the same clock as the write strobe and is sent in the following frame.
- R7: A frame that ends with fewer or more than 32 rising edges gives no strobe. It leaves `wr_data_o` unchanged and does not reload the response word.
- R8: While `cs_n_i` is high, `sdo_o` is 0 within 3 clocks, and `sck_i` or `sdi_i` activity has no effect.
- R9: Frames work correctly when every serial clock phase and the chip select setup and hold each last exactly 3 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, idle low, asynchronous |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| irq_i | input | 1 | Interrupt flag shown at frame start |
| rd_data_i | input | 31 | Response data captured at the end of a good frame |
| wr_valid_o | output | 1 | One-clock strobe for a complete frame |
| wr_data_o | output | 32 | Received word |

## Verification
The bench uses the default parameters: a 32-bit frame and a two-stage synchroniser. With these values, one phase of the serial clock can be as short as the three-clock minimum and still be caught reliably. The 32-bit frame exercises the full word in both directions, including the interrupt slot and the least significant response bit. It also exercises the bit counter's saturation point just past the frame length, which a 33-bit frame hits. Phase lengths of three and four clocks check the latency budget at its tight edge and with slack to spare.

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int FRAME_BITS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n_i,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  input  logic                  irq_i,
  input  logic [FRAME_BITS-2:0] rd_data_i,
  output logic                  wr_valid_o,
  output logic [FRAME_BITS-1:0] wr_data_o
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] OVER = CW'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, sdi_sync;
  logic                   cs_q, sck_q;
  logic [CW-1:0]          bit_cnt;
  logic [FRAME_BITS-1:0]  rx_sh;
  logic [FRAME_BITS-2:0]  tx_sh, resp_q;
  logic                   sdo_q, wr_valid_q;
  logic [FRAME_BITS-1:0]  wr_data_q;

  wire cs_s     = cs_sync[SYNC_STAGES-1];
  wire sck_s    = sck_sync[SYNC_STAGES-1];
  wire sdi_s    = sdi_sync[SYNC_STAGES-1];
  wire active   = ~cs_q & ~cs_s;
  wire cs_fall  = cs_q & ~cs_s;
  wire cs_rise  = ~cs_q & cs_s;
  wire sck_rise = active & ~sck_q & sck_s;
  wire sck_fall = active & sck_q & ~sck_s;
  wire frame_ok = cs_rise & (bit_cnt == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sync  <= '1;
      sck_sync <= '0;
      sdi_sync <= '0;
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], sdi_i};
      cs_q     <= cs_s;
      sck_q    <= sck_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      rx_sh <= {rx_sh[FRAME_BITS-2:0], sdi_s};
      if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid_q <= 1'b0;
      wr_data_q  <= '0;
      resp_q     <= '0;
    end else begin
      wr_valid_q <= frame_ok;
      if (frame_ok) begin
        wr_data_q <= rx_sh;
        resp_q    <= rd_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
      tx_sh <= '0;
    end else if (cs_fall) begin
      sdo_q <= irq_i;
      tx_sh <= resp_q;
    end else if (cs_s) begin
      sdo_q <= 1'b0;
    end else if (sck_fall) begin
      sdo_q <= tx_sh[FRAME_BITS-2];
      tx_sh <= {tx_sh[FRAME_BITS-3:0], 1'b0};
    end
  end

  assign sdo_o      = sdo_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_data_o  = wr_data_q;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int FRAME_BITS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n_i,
  input logic                  sdo_o,
  input logic                  wr_valid_o,
  input logic [FRAME_BITS-1:0] wr_data_o,
  input logic [$clog2(FRAME_BITS+2)-1:0] bit_cnt
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o); // R3
  AST_DATA_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_data_o) |-> wr_valid_o); // R7
  AST_STROBE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(bit_cnt) == ($clog2(FRAME_BITS+2))'(FRAME_BITS)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= ($clog2(FRAME_BITS+2))'(FRAME_BITS + 1)); // R2
  AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_o); // R8
endmodule

bind spi_reg_port spi_reg_port_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sdo_o(sdo_o),
  .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .bit_cnt(bit_cnt)
);

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n_i = 1'b1, sck_i = 1'b0, sdi_i = 1'b0, irq_i = 1'b0;
  logic [30:0] rd_data_i = '0;
  logic        sdo_o, wr_valid_o;
  logic [31:0] wr_data_o;
  int          n_chk = 0, n_err = 0, pulses = 0;
  logic [30:0] resp_m = '0;

  always #2.5 clk = ~clk;

  spi_reg_port i_spi_reg_port (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .irq_i(irq_i), .rd_data_i(rd_data_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o)
  );

  always @(posedge clk) if (rst_n && wr_valid_o) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] mosi, input int nbits, input int ph,
                       output logic [31:0] miso);
    miso = '0;
    @(negedge clk);
    cs_n_i = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdi_i = (i < 32) ? mosi[31-i] : 1'b0;
      wait_n(ph);
      if (i < 32) miso = {miso[30:0], sdo_o};
      sck_i = 1'b1;
      wait_n(ph);
      sck_i = 1'b0;
    end
    wait_n(ph);
    cs_n_i = 1'b1;
    wait_n(6);
  endtask

  task automatic t_reset;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 sdo", {31'b0, sdo_o}, 0);
    chk("R1 wr_valid", {31'b0, wr_valid_o}, 0);
    chk("R1 wr_data", wr_data_o, 0);
  endtask

  task automatic good_frame(input string req, input logic [31:0] mosi, input int ph,
                            input logic irq, input logic [30:0] rd);
    logic [31:0] miso;
    int p0;
    p0 = pulses;
    irq_i = irq;
    rd_data_i = rd;
    frame(mosi, 32, ph, miso);
    chk({req, " R4 R5 response"}, miso, {irq, resp_m});
    chk({req, " R2 R3 wr_data"}, wr_data_o, mosi);
    chk({req, " R3 one strobe"}, pulses - p0, 1);
    resp_m = rd;
  endtask

  task automatic t_basic;
    good_frame("basic1", 32'hA5C3_0F12, 4, 1'b1, 31'h1234_5678);
    good_frame("basic2", 32'h5A5A_F0F0, 4, 1'b0, 31'h7FFF_0001);
  endtask

  task automatic t_short;
    logic [31:0] miso;
    int p0;
    logic [31:0] w0;
    p0 = pulses;
    w0 = wr_data_o;
    irq_i = 1'b1;
    rd_data_i = 31'h0;
    frame(32'hFFC0_0000, 10, 4, miso);
    chk("R4 R5 short prefix", miso, {22'b0, 1'b1, resp_m[30:22]});
    chk("R7 short no strobe", pulses - p0, 0);
    chk("R7 short data kept", wr_data_o, w0);
    chk("R8 sdo low idle", {31'b0, sdo_o}, 0);
  endtask

  task automatic t_long;
    logic [31:0] miso;
    int p0;
    logic [31:0] w0;
    p0 = pulses;
    w0 = wr_data_o;
    irq_i = 1'b0;
    rd_data_i = 31'h0;
    frame(32'h1357_9BDF, 33, 4, miso);
    chk("R7 long resp unchanged", miso, {1'b0, resp_m});
    chk("R7 long no strobe", pulses - p0, 0);
    chk("R7 long data kept", wr_data_o, w0);
  endtask

  task automatic t_idle_sck;
    int p0;
    p0 = pulses;
    sdi_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sck_i = 1'b1; wait_n(4);
      sck_i = 1'b0; wait_n(4);
    end
    chk("R8 idle sck no strobe", pulses - p0, 0);
    chk("R8 idle sdo", {31'b0, sdo_o}, 0);
    good_frame("R8 after idle", 32'h0F0F_1234, 4, 1'b1, 31'h2AAA_AAAA);
  endtask

  task automatic t_min_timing;
    good_frame("R9 min1", 32'hFFFF_0000, 3, 1'b0, 31'h5555_5555);
    good_frame("R9 min2", 32'h0000_0001, 3, 1'b1, 31'h0000_0003);
    good_frame("R6 lsb", 32'h8000_0000, 3, 1'b0, 31'h0);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_short;
    t_long;
    t_idle_sck;
    t_min_timing;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule